// File: doc/BRIEF.md
# DisplayPort Lane Power-State Handshake Controller

This controller moves a group of DisplayPort transmitter lanes between the four link power states (A0, A1, A2, A3). A single start pulse carries a two-bit target state. If the PHY's common-ready status is low, the controller refuses the request. If common-ready is high, it drives a one-hot request field toward the PHY, polls the PHY's returned acknowledge field at a fixed sample interval, and finishes when that field equals the request exactly. If no match arrives within a bounded number of samples, it finishes with a timeout instead.

The controller also owns the link-reset-release bit. Initial bring-up sets this bit in the same step as the first A2 request, and it stays set afterwards. The outcome of every attempt is held on a result code until the next accepted start. While an attempt is in progress, a busy flag is high. The PHY-side power sequencing is outside this block.

Top module: `dp_pwr_handshake`

## Requirements
- R1: After reset, `req_o` is 4'b0000, `link_up_o` is 0, `busy_o` is 0 and `result_o` is 2'd0 (none).
- R2: If a start is seen while idle and `cmn_ready_i` is low, the attempt is refused. `result_o` becomes 2'd2 (not-ready) after that clock edge, `busy_o` stays low, and `req_o` keeps its previous value.
- R3: An accepted start drives `req_o` one-hot from `target_i`: code 0 (A0) gives bit 0, code 1 (A1) gives bit 1, code 2 (A2) gives bit 2, and code 3 (A3) gives bit 3. `req_o` never has more than one bit set. `link_up_o` is not changed by the request field.
- R4: An attempt completes with `result_o` = 2'd1 (ok) only when a sampled `ack_i` equals `req_o` in all four bits. An acknowledge with extra bits set is not a match.
- R5: `ack_i` is sampled at every SAMPLE_DIV-th clock edge after the acceptance edge. An attempt therefore ends at edge n*SAMPLE_DIV, where n is the first sample that sees a match.
- R6: If none of TIMEOUT_SAMPLES samples matches, the attempt ends at edge SAMPLE_DIV*TIMEOUT_SAMPLES with `result_o` = 2'd3 (timeout). A match on the last sample still gives ok.
- R7: `link_up_o` is set by an accepted start that has `bringup_i` high and target A2. Once set, it stays set until reset. A bring-up start with any other target leaves it unchanged.
- R8: A start while `busy_o` is high is ignored. It does not change `req_o` or the running attempt.
- R9: `busy_o` is high from the acceptance edge until the result is written. An accepted start clears `result_o` to none. Otherwise `result_o` holds its value until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a power-state change |
| target_i | input | 2 | Target state code: 0=A0, 1=A1, 2=A2, 3=A3 |
| bringup_i | input | 1 | With target A2, also releases the link reset |
| cmn_ready_i | input | 1 | PHY common-ready status |
| ack_i | input | 4 | One-hot acknowledge returned by the PHY |
| req_o | output | 4 | One-hot power-state request to the PHY |
| link_up_o | output | 1 | Link reset released |
| busy_o | output | 1 | Attempt in progress |
| result_o | output | 2 | 0 none, 1 ok, 2 not-ready, 3 timeout |

## Verification
The bench uses SAMPLE_DIV=4 and TIMEOUT_SAMPLES=8, so the timeout window is 32 cycles. At that size, a PHY model with an acknowledge delay of a few cycles can land a match exactly on the last sample, and can also miss it by one cycle. These settings also make every completion latency a small multiple of four that can be predicted from the model's delay. Re-requesting the current state, refused starts, starts during busy and a malformed acknowledge are each reached in a few dozen cycles.

// File: rtl/dp_pwr_handshake.sv
module dp_pwr_handshake #(
  parameter int SAMPLE_DIV      = 10,
  parameter int TIMEOUT_SAMPLES = 10000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] target_i,
  input  logic       bringup_i,
  input  logic       cmn_ready_i,
  input  logic [3:0] ack_i,
  output logic [3:0] req_o,
  output logic       link_up_o,
  output logic       busy_o,
  output logic [1:0] result_o
);

  localparam int DIV_W = $clog2(SAMPLE_DIV + 1);
  localparam int SMP_W = $clog2(TIMEOUT_SAMPLES + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SAMPLE_DIV - 1);
  localparam logic [SMP_W-1:0] SMP_LAST = SMP_W'(TIMEOUT_SAMPLES - 1);

  localparam logic [1:0] RES_NONE    = 2'd0;
  localparam logic [1:0] RES_OK      = 2'd1;
  localparam logic [1:0] RES_NOTRDY  = 2'd2;
  localparam logic [1:0] RES_TIMEOUT = 2'd3;

  logic [3:0]       req_q;
  logic             link_q;
  logic             busy_q;
  logic [1:0]       res_q;
  logic [DIV_W-1:0] div_q;
  logic [SMP_W-1:0] smp_q;

  wire accept   = start_i && !busy_q;
  wire sample   = busy_q && (div_q == DIV_LAST);
  wire matched  = (ack_i == req_q);
  wire last_smp = (smp_q == SMP_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      link_q <= 1'b0;
      busy_q <= 1'b0;
      res_q  <= RES_NONE;
      div_q  <= '0;
      smp_q  <= '0;
    end else if (accept) begin
      if (!cmn_ready_i) begin
        res_q <= RES_NOTRDY;
      end else begin
        req_q  <= 4'b0001 << target_i;
        busy_q <= 1'b1;
        res_q  <= RES_NONE;
        div_q  <= '0;
        smp_q  <= '0;
        if (bringup_i && target_i == 2'd2) link_q <= 1'b1;
      end
    end else if (sample) begin
      div_q <= '0;
      if (matched) begin
        busy_q <= 1'b0;
        res_q  <= RES_OK;
      end else if (last_smp) begin
        busy_q <= 1'b0;
        res_q  <= RES_TIMEOUT;
      end else begin
        smp_q <= smp_q + 1'b1;
      end
    end else if (busy_q) begin
      div_q <= div_q + 1'b1;
    end
  end

  assign req_o     = req_q;
  assign link_up_o = link_q;
  assign busy_o    = busy_q;
  assign result_o  = res_q;

endmodule

// File: rtl/dp_pwr_handshake_chk.sv
module dp_pwr_handshake_chk #(
  parameter int SAMPLE_DIV      = 10,
  parameter int TIMEOUT_SAMPLES = 10000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       cmn_ready_i,
  input logic [3:0] ack_i,
  input logic [3:0] req_o,
  input logic       link_up_o,
  input logic       busy_o,
  input logic [1:0] result_o
);

  localparam int LIMIT = SAMPLE_DIV * TIMEOUT_SAMPLES;

  logic [31:0] busy_cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_cyc <= '0;
    else if (busy_o) busy_cyc <= busy_cyc + 1;
    else             busy_cyc <= '0;
  end

  assert_req_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_o));

  assert_refuse_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !cmn_ready_i) |=> (result_o == 2'd2 && !busy_o && $stable(req_o)));

  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(req_o));

  assert_ok_exact_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o || result_o != 2'd1 || $past(ack_i) == req_o));

  assert_result_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(result_o));

  assert_timeout_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_o) && result_o == 2'd3) |-> busy_cyc == LIMIT);

  assert_link_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    link_up_o |=> link_up_o);

endmodule

bind dp_pwr_handshake dp_pwr_handshake_chk #(
  .SAMPLE_DIV(SAMPLE_DIV),
  .TIMEOUT_SAMPLES(TIMEOUT_SAMPLES)
) i_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmn_ready_i(cmn_ready_i),
  .ack_i(ack_i), .req_o(req_o), .link_up_o(link_up_o), .busy_o(busy_o),
  .result_o(result_o)
);

// File: tb/test_dp_pwr_handshake.sv
`timescale 1ns/1ps
module test_dp_pwr_handshake;
  localparam int SD = 4;
  localparam int TS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] target = 2'd0;
  logic bringup = 1'b0;
  logic ready = 1'b1;
  logic [3:0] ack = 4'b0000;
  logic [3:0] req;
  logic link_up, busy;
  logic [1:0] result;

  int errors = 0;
  int checks = 0;
  int dly = 1;
  logic bad_ack = 1'b0;

  always #2.5 clk = ~clk;

  dp_pwr_handshake #(.SAMPLE_DIV(SD), .TIMEOUT_SAMPLES(TS)) i_dp_pwr_handshake (
    .clk(clk), .rst_n(rst_n), .start_i(start), .target_i(target),
    .bringup_i(bringup), .cmn_ready_i(ready), .ack_i(ack),
    .req_o(req), .link_up_o(link_up), .busy_o(busy), .result_o(result)
  );

  // PHY model: acknowledge follows the request after dly cycles
  logic [3:0] seen = 4'b0000;
  int cnt = 0;
  always @(posedge clk) begin
    if (req != seen) begin
      seen <= req;
      cnt  <= dly;
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) ack <= bad_ack ? (seen | 4'b1000) : seen;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int cyc;
  task automatic run(input logic [1:0] t, input int d, input logic bu);
    dly = d;
    @(negedge clk);
    start = 1'b1; target = t; bringup = bu;
    @(posedge clk);
    cyc = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      start = 1'b0; bringup = 1'b0;
      if (!busy) break;
      @(posedge clk);
      cyc++;
    end
  endtask

  // target, delay, expected result, expected latency
  localparam logic [17:0] VEC [7] = '{
    {2'd2, 8'd1,  2'd1, 6'd4},
    {2'd0, 8'd5,  2'd1, 6'd8},
    {2'd3, 8'd10, 2'd1, 6'd12},
    {2'd1, 8'd30, 2'd1, 6'd32},
    {2'd2, 8'd31, 2'd3, 6'd32},
    {2'd2, 8'd3,  2'd1, 6'd4},
    {2'd0, 8'd2,  2'd1, 6'd4}
  };

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 req", req, 0);
    chk("R1 link", link_up, 0);
    chk("R1 busy", busy, 0);
    chk("R1 result", result, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 7; i++) begin
      run(VEC[i][17:16], int'(VEC[i][15:8]), 1'b0);
      chk($sformatf("R4 vec%0d result", i), result, VEC[i][7:6]);
      chk($sformatf("R5 R6 vec%0d latency", i), cyc, VEC[i][5:0]);
      chk($sformatf("R3 vec%0d req", i), req, 4'b0001 << VEC[i][17:16]);
      repeat (40) @(negedge clk);
      chk($sformatf("R9 vec%0d held", i), result, VEC[i][7:6]);
    end
    chk("R7 no link without bringup", link_up, 0);

    // R2: refused when common-ready low
    ready = 1'b0;
    run(2'd3, 2, 1'b0);
    chk("R2 result", result, 2);
    chk("R2 busy", cyc, 0);
    chk("R2 req unchanged", req, 4'b0001);
    ready = 1'b1;

    // R4: acknowledge with an extra bit is not a match
    bad_ack = 1'b1;
    run(2'd1, 2, 1'b0);
    chk("R4 malformed ack result", result, 3);
    chk("R6 malformed ack latency", cyc, SD * TS);
    bad_ack = 1'b0;
    repeat (20) @(negedge clk);

    // R7: bringup with A3 leaves link bit; with A2 sets it
    run(2'd3, 2, 1'b1);
    chk("R7 bringup A3 no link", link_up, 0);
    repeat (10) @(negedge clk);
    run(2'd2, 2, 1'b1);
    chk("R7 bringup A2 link", link_up, 1);
    chk("R3 req A2 with link", req, 4'b0100);
    repeat (10) @(negedge clk);
    run(2'd0, 2, 1'b0);
    chk("R7 link sticky", link_up, 1);
    repeat (10) @(negedge clk);

    // R8: start during busy ignored
    dly = 6;
    @(negedge clk);
    start = 1'b1; target = 2'd3;
    @(negedge clk);
    start = 1'b0;
    chk("R9 busy after accept", busy, 1);
    chk("R9 result cleared", result, 0);
    @(negedge clk);
    start = 1'b1; target = 2'd1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 req unchanged", req, 4'b1000);
    repeat (10) @(negedge clk);
    chk("R8 completes ok", result, 1);
    chk("R8 req final", req, 4'b1000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule